// File: doc/BRIEF.md
# Row-Parallel Readout Sequencer

This block generates the timing for a two-dimensional photodiode array that is read one whole row at a time. At the start of each row it raises a sense strobe for a fixed number of clocks. During that time the per-column integrating amplifiers capture the row in parallel. A store strobe follows for a fixed number of clocks and moves the sensed values into a holding array. The sequencer then scans a column pointer across the row, one column per enabled pixel clock, so the held values leave through a single output path. A line-valid flag is high for the whole scan.

After the last active row, the row pointer visits one extra row at the bottom of the array. That row is shielded from light and is read as a black reference. While the row pointer is on it, the block drives a complementary pair of switch controls. The calibrate switch turns on and the cascode switch turns off, so the held current reference is refreshed once per field. The switch changes are separated by one dead clock. When the reference row ends, a one-clock field-end pulse marks the wrap to row 0. A pixel enable can pause the column scan, so that slow digitising rates use the same sequencer.

Top module: `readout_sequencer`

## Requirements
- R1: A synchronous reset puts the block in this state: row_sel = 0, col_sel = 0, sense = 1, store = 0, line_valid = 0, cal_a = 0, cal_b = 1, field_end = 0.
- R2: Each row begins with sense high for exactly SENSE_CYC clocks, followed by store high for exactly STORE_CYC clocks. In every cycle, exactly one of sense, store and line_valid is high.
- R3: line_valid is high only during the column scan. During the scan, col_sel starts at 0 and rises by one on each clock where pix_en = 1, up to COLS-1.
- R4: When pix_en = 0, col_sel holds and the scan does not end. pix_en has no effect on the length of the sense and store phases.
- R5: The row advances in the clock after pix_en = 1 with col_sel = COLS-1. row_sel steps through 0 to ROWS-1 and then reaches ROWS, the reference row, where ref_row is high. After the reference row, row_sel wraps to 0.
- R6: field_end is high for exactly one clock. That clock is the first cycle of row 0 after the reference row has been scanned.
- R7: cal_a and cal_b are never high together. cal_a rises two clocks after ref_row rises; cal_b falls one clock after ref_row rises. When ref_row falls, cal_a falls one clock later and cal_b rises one clock after that, so one clock is left dead.
- R8: col_sel is 0 whenever line_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Advances the column scan when high |
| row_sel | output | $clog2(ROWS+1) | Row pointer; the value ROWS addresses the shielded row |
| col_sel | output | $clog2(COLS) | Column pointer |
| sense | output | 1 | Row-sense phase strobe |
| store | output | 1 | Store-to-holding-array strobe |
| line_valid | output | 1 | Column scan in progress |
| cal_a | output | 1 | Calibrate switch control |
| cal_b | output | 1 | Cascode switch control |
| ref_row | output | 1 | Reference row is addressed |
| field_end | output | 1 | One-clock pulse at the wrap to row 0 |

## Verification
The clock that ends the reference row does three things at once. It raises field_end, it moves the row pointer from ROWS to 0 and back into the sense phase, and it starts the cal_a-off, dead clock, cal_b-on sequence. A further change can land on that same clock: pix_en drops while the last column of the reference row is shown. This stretches the window and shifts all three events together. Random pix_en patterns on a small array produce this coincidence in many fields. A cycle-level model built from the requirements judges every output in every cycle, with a mid-field reset and a long pause as directed cases.

// File: rtl/readout_sequencer.sv
module readout_sequencer #(
  parameter int COLS      = 312,
  parameter int ROWS      = 287,
  parameter int SENSE_CYC = 4,
  parameter int STORE_CYC = 2,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  output logic [RW-1:0] row_sel,
  output logic [CW-1:0] col_sel,
  output logic          sense,
  output logic          store,
  output logic          line_valid,
  output logic          cal_a,
  output logic          cal_b,
  output logic          ref_row,
  output logic          field_end
);

  localparam int LONGEST = (SENSE_CYC > STORE_CYC) ? SENSE_CYC : STORE_CYC;
  localparam int PW = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {PH_SENSE, PH_STORE, PH_SCAN} phase_t;

  phase_t        ph;
  logic [PW-1:0] cnt;

  assign sense      = (ph == PH_SENSE);
  assign store      = (ph == PH_STORE);
  assign line_valid = (ph == PH_SCAN);
  assign ref_row    = (row_sel == RW'(ROWS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_SENSE;
      cnt       <= '0;
      row_sel   <= '0;
      col_sel   <= '0;
      field_end <= 1'b0;
      cal_a     <= 1'b0;
      cal_b     <= 1'b1;
    end else begin
      field_end <= 1'b0;
      cal_a     <= ref_row && !cal_b;
      cal_b     <= !ref_row && !cal_a;
      unique case (ph)
        PH_SENSE:
          if (cnt == PW'(SENSE_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_STORE;
          end else cnt <= cnt + 1'b1;
        PH_STORE:
          if (cnt == PW'(STORE_CYC - 1)) begin
            cnt <= '0;
            ph  <= PH_SCAN;
          end else cnt <= cnt + 1'b1;
        PH_SCAN:
          if (pix_en) begin
            if (col_sel == CW'(COLS - 1)) begin
              col_sel <= '0;
              ph      <= PH_SENSE;
              if (ref_row) begin
                row_sel   <= '0;
                field_end <= 1'b1;
              end else row_sel <= row_sel + 1'b1;
            end else col_sel <= col_sel + 1'b1;
          end
        default: ph <= PH_SENSE;
      endcase
    end
  end

endmodule

// File: rtl/readout_sequencer_chk.sv
module readout_sequencer_chk #(
  parameter int COLS = 312,
  parameter int ROWS = 287,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [RW-1:0] row_sel,
  input logic [CW-1:0] col_sel,
  input logic          sense,
  input logic          store,
  input logic          line_valid,
  input logic          cal_a,
  input logic          cal_b,
  input logic          ref_row,
  input logic          field_end
);

  a_r7_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cal_a && cal_b));

  a_r7_dead_before_a: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_a) |-> $past(!cal_b));

  a_r7_dead_before_b: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_b) |-> $past(!cal_a));

  a_r7_a_in_window: assert property (@(posedge clk) disable iff (rst)
    cal_a |-> $past(ref_row));

  a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot({sense, store, line_valid}));

  a_r4_pause_holds: assert property (@(posedge clk) disable iff (rst)
    line_valid && !pix_en |=> line_valid && $stable(col_sel));

  a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
    line_valid && pix_en && (col_sel != CW'(COLS - 1)) |=>
      line_valid && (col_sel == $past(col_sel) + 1'b1));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    field_end |=> !field_end);

  a_r6_at_wrap: assert property (@(posedge clk) disable iff (rst)
    field_end |-> (row_sel == '0) && sense);

  a_r8_col_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> (col_sel == '0));

endmodule

bind readout_sequencer readout_sequencer_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .row_sel(row_sel), .col_sel(col_sel),
  .sense(sense), .store(store), .line_valid(line_valid), .cal_a(cal_a),
  .cal_b(cal_b), .ref_row(ref_row), .field_end(field_end)
);

// File: tb/readout_sequencer_bench.sv
`timescale 1ns/1ps
module readout_sequencer_bench;
  localparam int C = 5, R = 3, S = 3, T = 2;
  localparam int CW = $clog2(C), RW = $clog2(R + 1);

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0;
  logic [RW-1:0] row_sel;
  logic [CW-1:0] col_sel;
  logic sense, store, line_valid, cal_a, cal_b, ref_row, field_end;

  readout_sequencer #(.COLS(C), .ROWS(R), .SENSE_CYC(S), .STORE_CYC(T)) u_readout_sequencer (
    .clk(clk), .rst(rst), .pix_en(pix_en), .row_sel(row_sel), .col_sel(col_sel),
    .sense(sense), .store(store), .line_valid(line_valid), .cal_a(cal_a),
    .cal_b(cal_b), .ref_row(ref_row), .field_end(field_end));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_ph, m_cnt, m_row, m_col, m_fe, m_a, m_b, prev_en, fields;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_cnt = 0; m_row = 0; m_col = 0; m_fe = 0; m_a = 0; m_b = 1; prev_en = 1;
  endtask

  task automatic model_step(input int en);
    int fe_n, a_n, b_n;
    fe_n = 0;
    a_n = (m_row == R) && !m_b;
    b_n = (m_row != R) && !m_a;
    case (m_ph)
      0: if (m_cnt == S - 1) begin m_cnt = 0; m_ph = 1; end else m_cnt++;
      1: if (m_cnt == T - 1) begin m_cnt = 0; m_ph = 2; end else m_cnt++;
      default:
        if (en != 0) begin
          if (m_col == C - 1) begin
            m_col = 0; m_ph = 0;
            if (m_row == R) begin m_row = 0; fe_n = 1; end else m_row++;
          end else m_col++;
        end
    endcase
    m_fe = fe_n; m_a = a_n; m_b = b_n; prev_en = en;
  endtask

  task automatic compare();
    chk("R2 sense", int'(sense), int'(m_ph == 0));
    chk("R2 store", int'(store), int'(m_ph == 1));
    chk("R3 line_valid", int'(line_valid), int'(m_ph == 2));
    if (m_ph != 2) chk("R8 col_sel idle", int'(col_sel), 0);
    else if (prev_en == 0) chk("R4 col_sel paused", int'(col_sel), m_col);
    else chk("R3 col_sel", int'(col_sel), m_col);
    chk("R5 row_sel", int'(row_sel), m_row);
    chk("R5 ref_row", int'(ref_row), int'(m_row == R));
    chk("R6 field_end", int'(field_end), m_fe);
    if (field_end) fields++;
    chk("R7 cal_a", int'(cal_a), m_a);
    chk("R7 cal_b", int'(cal_b), m_b);
  endtask

  task automatic cycle(input int en);
    compare();
    pix_en = (en != 0);
    model_step(en);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 row_sel", int'(row_sel), 0);
    chk("R1 col_sel", int'(col_sel), 0);
    chk("R1 sense", int'(sense), 1);
    chk("R1 line_valid", int'(line_valid), 0);
    chk("R1 cal_a", int'(cal_a), 0);
    chk("R1 cal_b", int'(cal_b), 1);
    chk("R1 field_end", int'(field_end), 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    fields = 0;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 30; i++) cycle(0);
    for (int i = 0; i < 200; i++) cycle(1);
    for (int i = 0; i < 900; i++) cycle(($urandom % 4) != 0 ? 1 : 0);
    for (int i = 0; i < 17; i++) cycle(1);
    do_reset();
    for (int i = 0; i < 600; i++) cycle(($urandom % 2) != 0 ? 1 : 0);
    checks++;
    if (fields < 5) begin
      errors++;
      $display("FAIL R6 field count: actual %0d expected at least 5", fields);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule